// File: doc/BRIEF.md
# Output Delay Coarse/Fine Splitter

This block divides a requested output time into the two settings that an output stage needs. That stage is built from an 8 ns system-clock counter followed by an external programmable delay line. The request arrives as a whole number of 8 ns cycles plus a binary fraction of one cycle. The whole part passes through unchanged as the coarse cycle on which the output fires. The fraction is converted into a delay-line tap code by multiplying the sub-cycle remainder, in nanoseconds, by a calibrated taps-per-nanosecond factor (alpha).

Alpha is an input in unsigned fixed point with 12 fractional bits. The nominal tap of 10 ps gives 100 taps/ns, which is the code 409600. Calibration at startup sets alpha, and a temperature-drift correction may change it at any time while the outputs keep running. The block reads alpha only in the cycle that the request strobe is high. A later change therefore never alters a computation already under way. The tap code is rounded to the nearest tap and limited to the largest code the delay line accepts. Each result appears two clock cycles after its strobe, with a one-cycle valid flag.

Top module: `dly_coarse_fine_split`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released with no strobe, out_valid, out_cycle and out_tap are all zero.
- R2: out_valid is high for exactly one cycle, two clock edges after the edge that samples req_valid high, and is low otherwise. Back-to-back strobes produce back-to-back results.
- R3: out_cycle equals the req_cycles value sampled together with the strobe.
- R4: With frac = req_frac (in units of 8 ns / 4096) and alpha in units of 1/4096 tap per ns, out_tap equals alpha*frac*8 / 2^24, rounded to the nearest integer with halves rounded up. This holds whenever that value does not exceed 1023.
- R5: When the rounded value of R4 exceeds 1023, out_tap is 1023.
- R6: A req_frac of zero yields out_tap of zero for any alpha.
- R7: Only the alpha present in the strobe cycle is used. Alpha, req_frac or req_cycles changing in the cycles after the strobe has no effect on that result.
- R8: At the nominal alpha of 409600 (100 taps/ns), a remainder of half a cycle (req_frac 2048, 4 ns) gives 400 taps.
- R9: In cycles without a new result, out_cycle and out_tap keep the values of the last result.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one coarse 8 ns step per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Strobe: a new request is present this cycle |
| req_cycles | input | 32 | Whole 8 ns cycles of the requested time |
| req_frac | input | 12 | Fraction of one cycle, units of 8 ns / 4096 |
| alpha | input | 20 | Calibrated taps per ns, 12 fractional bits |
| out_valid | output | 1 | One-cycle flag: out_cycle and out_tap are new |
| out_cycle | output | 32 | Coarse cycle on which the output fires |
| out_tap | output | 10 | Fine delay-line tap code |

## Verification
Random requests with alpha near its nominal value exercise the rounding rule over the normal tap range. Random alpha over its whole span pushes many products past the tap ceiling, which separates correct saturation from wrap-around. Directed cases cover a zero fraction with a large alpha, the exact nominal point, the largest fraction and alpha, and results that sit on a rounding half. Between each strobe and its result, the bench scrambles alpha, the fraction and the cycle count, and it sends back-to-back strobes with different alphas. These show whether the block latched its operands at the strobe or reads them late.

// File: rtl/dly_split_pkg.sv
package dly_split_pkg;
  localparam int DEF_CYC_W       = 32;
  localparam int DEF_FRAC_W      = 12;
  localparam int DEF_ALPHA_W     = 20;
  localparam int DEF_ALPHA_FRAC  = 12;
  localparam int DEF_CYC_NS_LOG2 = 3;
  localparam int DEF_TAP_W       = 10;
  localparam int DEF_TAP_MAX     = 1023;
endpackage

// File: rtl/dly_frac_mult.sv
module dly_frac_mult #(
  parameter int CW = 32,
  parameter int FW = 12,
  parameter int AW = 20,
  localparam int PW = AW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [CW-1:0] cycles_in,
  input  logic [FW-1:0] frac_in,
  input  logic [AW-1:0] alpha_in,
  output logic          s1_valid,
  output logic [CW-1:0] s1_cycles,
  output logic [PW-1:0] s1_prod,
  output logic          s1_frac_zero
);
  function automatic logic [PW-1:0] mul_u(input logic [AW-1:0] a, input logic [FW-1:0] f);
    return PW'(a) * PW'(f);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid     <= 1'b0;
      s1_cycles    <= '0;
      s1_prod      <= '0;
      s1_frac_zero <= 1'b0;
    end else begin
      s1_valid <= strobe;
      if (strobe) begin
        s1_cycles    <= cycles_in;
        s1_prod      <= mul_u(alpha_in, frac_in);
        s1_frac_zero <= (frac_in == '0);
      end
    end
  end
endmodule

// File: rtl/dly_tap_quant.sv
module dly_tap_quant #(
  parameter int PW      = 32,
  parameter int SHIFT   = 21,
  parameter int TW      = 10,
  parameter int TAP_MAX = 1023,
  localparam int QW     = PW + 1 - SHIFT
) (
  input  logic [PW-1:0] prod,
  output logic [TW-1:0] tap,
  output logic          clamped
);
  localparam logic [PW:0] HALF = (PW+1)'(1) << (SHIFT - 1);

  function automatic logic [QW-1:0] round_half_up(input logic [PW-1:0] p);
    logic [PW:0] s;
    s = {1'b0, p} + HALF;
    return s[PW:SHIFT];
  endfunction

  logic [QW-1:0] q;

  always_comb begin
    q       = round_half_up(prod);
    clamped = ({{TW{1'b0}}, q} > (QW+TW)'(TAP_MAX));
    tap     = clamped ? TW'(TAP_MAX) : TW'(q);
  end
endmodule

// File: rtl/dly_out_reg.sv
module dly_out_reg #(
  parameter int CW = 32,
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_cycle,
  input  logic [TW-1:0] in_tap,
  output logic          out_valid,
  output logic [CW-1:0] out_cycle,
  output logic [TW-1:0] out_tap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cycle <= '0;
      out_tap   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cycle <= in_cycle;
        out_tap   <= in_tap;
      end
    end
  end
endmodule

// File: rtl/dly_coarse_fine_split.sv
module dly_coarse_fine_split
  import dly_split_pkg::*;
#(
  parameter int CW          = DEF_CYC_W,
  parameter int FW          = DEF_FRAC_W,
  parameter int AW          = DEF_ALPHA_W,
  parameter int AFRAC       = DEF_ALPHA_FRAC,
  parameter int CYC_NS_LOG2 = DEF_CYC_NS_LOG2,
  parameter int TW          = DEF_TAP_W,
  parameter int TAP_MAX     = DEF_TAP_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_cycles,
  input  logic [FW-1:0] req_frac,
  input  logic [AW-1:0] alpha,
  output logic          out_valid,
  output logic [CW-1:0] out_cycle,
  output logic [TW-1:0] out_tap
);
  localparam int PW    = AW + FW;
  localparam int SHIFT = AFRAC + FW - CYC_NS_LOG2;

  logic          s1_valid;
  logic [CW-1:0] s1_cycles;
  logic [PW-1:0] s1_prod;
  logic          s1_frac_zero;
  logic [TW-1:0] q_tap;
  logic          q_clamped;

  dly_frac_mult #(.CW(CW), .FW(FW), .AW(AW)) u_mult (
    .clk(clk), .rst_n(rst_n), .strobe(req_valid),
    .cycles_in(req_cycles), .frac_in(req_frac), .alpha_in(alpha),
    .s1_valid(s1_valid), .s1_cycles(s1_cycles), .s1_prod(s1_prod),
    .s1_frac_zero(s1_frac_zero)
  );

  dly_tap_quant #(.PW(PW), .SHIFT(SHIFT), .TW(TW), .TAP_MAX(TAP_MAX)) u_quant (
    .prod(s1_prod), .tap(q_tap), .clamped(q_clamped)
  );

  dly_out_reg #(.CW(CW), .TW(TW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_cycle(s1_cycles),
    .in_tap(q_tap), .out_valid(out_valid), .out_cycle(out_cycle), .out_tap(out_tap)
  );
endmodule

// File: rtl/dly_split_checker.sv
module dly_split_checker #(
  parameter int CW      = 32,
  parameter int TW      = 10,
  parameter int TAP_MAX = 1023
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [CW-1:0] req_cycles,
  input logic          s1_valid,
  input logic          s1_frac_zero,
  input logic          q_clamped,
  input logic          out_valid,
  input logic [CW-1:0] out_cycle,
  input logic [TW-1:0] out_tap
);
  assert_strobe_to_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> s1_valid);
  assert_mid_to_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  assert_cycle_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 (out_cycle == $past(req_cycles, 2)));
  assert_tap_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && q_clamped |=> out_tap == TW'(TAP_MAX));
  assert_zero_frac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_frac_zero |=> out_tap == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_cycle) && $stable(out_tap));
endmodule

bind dly_coarse_fine_split dly_split_checker #(.CW(CW), .TW(TW), .TAP_MAX(TAP_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cycles(req_cycles),
  .s1_valid(s1_valid), .s1_frac_zero(s1_frac_zero), .q_clamped(q_clamped),
  .out_valid(out_valid), .out_cycle(out_cycle), .out_tap(out_tap)
);

// File: tb/dly_coarse_fine_split_bench.sv
`timescale 1ns/1ps
module dly_coarse_fine_split_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_cycles = '0;
  logic [11:0] req_frac = '0;
  logic [19:0] alpha = '0;
  logic        out_valid;
  logic [31:0] out_cycle;
  logic [9:0]  out_tap;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dly_coarse_fine_split u_dly_coarse_fine_split (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cycles(req_cycles),
    .req_frac(req_frac), .alpha(alpha), .out_valid(out_valid),
    .out_cycle(out_cycle), .out_tap(out_tap)
  );

  // Taps = alpha/4096 * (frac*8/4096) ns, nearest integer, halves up, ceiling 1023.
  function automatic longint exp_tap(input longint a, input longint f);
    longint num, den, q;
    num = a * f * 8;
    den = 64'd16777216;
    q = num / den;
    if ((num % den) * 2 >= den) q = q + 1;
    if (q > 1023) q = 1023;
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic scramble();
    alpha      = 20'($urandom);
    req_frac   = 12'($urandom);
    req_cycles = $urandom;
  endtask

  // Drive one request, scramble inputs afterwards (R7), check latency, value and hold.
  task automatic issue(input logic [31:0] cyc, input logic [11:0] fr, input logic [19:0] al);
    longint e;
    e = exp_tap(al, fr);
    req_cycles = cyc; req_frac = fr; alpha = al; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; scramble();
    check(out_valid == 1'b0, "R2 early", out_valid, 0);
    @(negedge clk);
    scramble();
    check(out_valid == 1'b1, "R2 valid", out_valid, 1);
    check(out_cycle == cyc, "R3 cycle", out_cycle, cyc);
    check(out_tap == e[9:0], (e == 1023) ? "R5/R7 tap" : "R4/R7 tap", out_tap, e);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 single", out_valid, 0);
    check(out_cycle == cyc && out_tap == e[9:0], "R9 hold", out_tap, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_cycle == 0 && out_tap == 0, "R1 in reset", out_tap, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 0 && out_cycle == 0 && out_tap == 0, "R1 after reset", out_cycle, 0);

    // R8 nominal point
    issue(32'd10, 12'd2048, 20'd409600);
    check(out_tap == 10'd400, "R8 nominal", out_tap, 400);
    // R6 zero fraction with large alpha
    issue(32'd77, 12'd0, 20'hFFFFF);
    check(out_tap == 10'd0, "R6 zero frac", out_tap, 0);
    // R5 largest inputs
    issue(32'hFFFF_FFFF, 12'hFFF, 20'hFFFFF);
    // R4 rounding half: 4096*512*8 = 2^24 -> 1 ; 2048*512*8 = 2^23 -> half -> 1
    issue(32'd5, 12'd512, 20'd2048);
    issue(32'd6, 12'd511, 20'd2048);
    issue(32'd7, 12'd1, 20'd409600);

    // R2 back-to-back with different alphas (R7)
    req_cycles = 32'd100; req_frac = 12'd3000; alpha = 20'd400000; req_valid = 1'b1;
    @(negedge clk);
    req_cycles = 32'd101; req_frac = 12'd3000; alpha = 20'd420000;
    @(negedge clk);
    req_valid = 1'b0; scramble();
    check(out_valid && out_cycle == 100, "R2 b2b first", out_cycle, 100);
    check(out_tap == 10'(exp_tap(400000, 3000)), "R7 b2b first", out_tap, exp_tap(400000, 3000));
    @(negedge clk);
    check(out_valid && out_cycle == 101, "R2 b2b second", out_cycle, 101);
    check(out_tap == 10'(exp_tap(420000, 3000)), "R7 b2b second", out_tap, exp_tap(420000, 3000));
    @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [19:0] a;
      logic [11:0] f;
      if (i % 3 == 0) a = 20'($urandom);
      else a = 20'(300000 + ($urandom % 220000));
      f = (i % 17 == 0) ? 12'd0 : 12'($urandom);
      issue($urandom, f, a);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule